// File: doc/BRIEF.md
# Strided Vector Load/Store Engine

This block executes one vector memory instruction at a time against its own word-interleaved memory of 16 banks. Two configuration registers are loaded over plain write-enable pins: an element count of up to 64 and an element stride. A command names the base word address and the direction, load or store. Once the command is accepted, the engine walks the elements in index order. Element i lives at word address `base + i*stride`, taken modulo the memory size. The engine offers at most one element per cycle to the bank that owns that address.

Every bank access occupies its bank for a fixed number of cycles, 11 by default. The engine keeps a countdown for each bank. When the next element maps to a bank that is still busy, the engine stalls in place until that bank is free. Stores take their data from a vector-register read port: the engine drives the element index and samples the data in the same cycle. Loads return their data on a vector-register write port in ascending element order, and each returned word carries its index.

The command interface is a valid/ready handshake. A command transfers on a clock edge where `cmd_valid` and `cmd_ready` are both high. `cmd_ready` is low while a command is running and in the cycle of its completion pulse, so a source must hold `cmd_valid` and its fields until the handshake. The write port has no back-pressure: the register file must accept every `wb_valid` beat.

Top module: `vmem_stride_unit`

## Requirements
- R1: After reset, `cmd_ready` is 1, `wb_valid` is 0 and `done` is 0.
- R2: A length write above 64 stores 64, and the stride register takes any 8-bit value. Both are sampled when a command is accepted, so writes during a running command do not change it.
- R3: Element i uses word address (base + i*stride) mod 256. Its bank is address bits [3:0] and its row is address bits [7:4].
- R4: A store writes, for element i, the `src_data` present while `src_idx` equals i. Elements are written in index order, so on overlapping addresses the higher index wins.
- R5: A load returns exactly one `wb_valid` beat per element, with `wb_idx` running 0, 1, … length-1 and `wb_data` equal to the word at that element's address.
- R6: A bank that starts an access accepts no further access for 11 cycles. While the next element's bank is busy, the element index does not advance.
- R7: Without bank conflicts, elements go out in consecutive cycles. A unit-stride load of length L raises `done` L+11 clock edges after the accepting edge, and a unit-stride store raises it after L edges.
- R8: `done` is a one-cycle pulse. For a load it follows the edge after the last returned beat. For a store it follows the edge that gave the last element to its bank.
- R9: A command with length 0 raises `done` right after the accepting edge, returns no load beats and writes no memory.
- R10: `cmd_ready` is low while a command is running.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| vlen_we | input | 1 | Write strobe for the element-count register |
| vlen_in | input | 7 | New element count, clamped to 64 |
| stride_we | input | 1 | Write strobe for the stride register |
| stride_in | input | 8 | New stride in words |
| cmd_valid | input | 1 | Command offered |
| cmd_ready | output | 1 | Engine can take a command |
| cmd_store | input | 1 | 1 = store, 0 = load |
| cmd_base | input | 8 | Base word address |
| src_idx | output | 6 | Element index being stored |
| src_data | input | 64 | Store data for `src_idx`, same cycle |
| wb_valid | output | 1 | Load element returned |
| wb_idx | output | 6 | Index of the returned element |
| wb_data | output | 64 | Returned word |
| done | output | 1 | One-cycle completion pulse |

## Verification
If a bank countdown is wrong, the completion pulse moves. The engine then either issues too early, which breaks the 11-cycle spacing on same-bank strides (0, 16, 32, …), or too late, and the `done` edge count differs from the bench schedule within a single command. If the address stepping or the element index is wrong, a load beat returns the wrong word or index as soon as that element comes back, and a store corrupts a word that the next full-coverage load exposes. If the return path loses or duplicates a beat, the beat count at `done` is off, and the engine can hang waiting for the final index, which the per-command timeout reports.

// File: rtl/vsu_pkg.sv
package vsu_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_ISSUE = 2'd1,
    ST_DRAIN = 2'd2
  } vsu_state_e;
endpackage

// File: rtl/vsu_bank_array.sv
module vsu_bank_array #(
  parameter int BANKS = 16,
  parameter int ROWS  = 16,
  parameter int LAT   = 11,
  parameter int DW    = 64,
  localparam int BANK_W = $clog2(BANKS),
  localparam int ROW_W  = $clog2(ROWS),
  localparam int AW     = BANK_W + ROW_W,
  localparam int CNT_W  = $clog2(LAT + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  input  logic             req_store,
  input  logic [AW-1:0]    req_addr,
  input  logic [DW-1:0]    req_wdata,
  output logic [BANKS-1:0] busy,
  output logic [DW-1:0]    rd_data
);
  logic [BANK_W-1:0] bank_sel;
  logic [ROW_W-1:0]  row_sel;
  logic [DW-1:0]     bank_rd [BANKS];

  assign bank_sel = req_addr[BANK_W-1:0];
  assign row_sel  = req_addr[AW-1:BANK_W];

  for (genvar b = 0; b < BANKS; b++) begin : g_bank
    logic [CNT_W-1:0] cnt_q;
    logic [DW-1:0]    mem [ROWS];
    logic             hit;

    assign hit        = req_valid && (bank_sel == BANK_W'(b));
    assign busy[b]    = (cnt_q != '0);
    assign bank_rd[b] = mem[row_sel];

    always_ff @(posedge clk) begin
      if (!rst_n)          cnt_q <= '0;
      else if (hit)        cnt_q <= CNT_W'(LAT - 1);
      else if (cnt_q != 0) cnt_q <= cnt_q - 1'b1;
    end

    always_ff @(posedge clk) begin
      if (hit && req_store) mem[row_sel] <= req_wdata;
    end
  end

  assign rd_data = bank_rd[bank_sel];

  // R6
  no_conflict_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |-> !busy[bank_sel]);
endmodule

// File: rtl/vsu_addr_gen.sv
module vsu_addr_gen
  import vsu_pkg::*;
#(
  parameter int BANKS  = 16,
  parameter int AW     = 8,
  parameter int LEN_W  = 7,
  parameter int IDX_W  = 6,
  localparam int BANK_W = $clog2(BANKS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cmd_valid,
  input  logic             cmd_store,
  input  logic [AW-1:0]    cmd_base,
  input  logic [LEN_W-1:0] cfg_len,
  input  logic [AW-1:0]    cfg_stride,
  input  logic [BANKS-1:0] busy,
  input  logic             ret_valid,
  input  logic [IDX_W-1:0] ret_idx,
  output logic             cmd_ready,
  output logic             req_valid,
  output logic             req_store,
  output logic [AW-1:0]    req_addr,
  output logic [IDX_W-1:0] req_idx,
  output logic             done
);
  vsu_state_e       state_q;
  logic [LEN_W-1:0] idx_q, len_q;
  logic [AW-1:0]    addr_q, stride_q;
  logic             store_q, done_q;
  logic             last_issue, last_ret;

  assign cmd_ready  = (state_q == ST_IDLE) && !done_q;
  assign req_valid  = (state_q == ST_ISSUE) && !busy[addr_q[BANK_W-1:0]];
  assign req_store  = store_q;
  assign req_addr   = addr_q;
  assign req_idx    = idx_q[IDX_W-1:0];
  assign done       = done_q;
  assign last_issue = req_valid && (idx_q == LEN_W'(len_q - 1'b1));
  assign last_ret   = ret_valid && (ret_idx == IDX_W'(len_q - 1'b1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q  <= ST_IDLE;
      idx_q    <= '0;
      len_q    <= '0;
      addr_q   <= '0;
      stride_q <= '0;
      store_q  <= 1'b0;
      done_q   <= 1'b0;
    end else begin
      done_q <= 1'b0;
      case (state_q)
        ST_IDLE: if (cmd_valid && cmd_ready) begin
          idx_q    <= '0;
          len_q    <= cfg_len;
          addr_q   <= cmd_base;
          stride_q <= cfg_stride;
          store_q  <= cmd_store;
          if (cfg_len == '0) done_q  <= 1'b1;
          else               state_q <= ST_ISSUE;
        end
        ST_ISSUE: if (req_valid) begin
          idx_q  <= idx_q + 1'b1;
          addr_q <= addr_q + stride_q;
          if (last_issue) begin
            if (store_q) begin
              done_q  <= 1'b1;
              state_q <= ST_IDLE;
            end else begin
              state_q <= ST_DRAIN;
            end
          end
        end
        ST_DRAIN: if (last_ret) begin
          done_q  <= 1'b1;
          state_q <= ST_IDLE;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  // R8
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  // R6
  idx_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_ISSUE) |-> (idx_q < len_q));
  // R6
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_ISSUE && !req_valid) |=> $stable(idx_q));
  // R10
  ready_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q != ST_IDLE) |-> !cmd_ready);
endmodule

// File: rtl/vsu_return_pipe.sv
module vsu_return_pipe #(
  parameter int LAT   = 11,
  parameter int IDX_W = 6,
  parameter int DW    = 64
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  input  logic [IDX_W-1:0] in_idx,
  input  logic [DW-1:0]    in_data,
  output logic             wb_valid,
  output logic [IDX_W-1:0] wb_idx,
  output logic [DW-1:0]    wb_data
);
  logic [LAT-1:0]   vld_q;
  logic [IDX_W-1:0] idx_q [LAT];
  logic [DW-1:0]    dat_q [LAT];

  always_ff @(posedge clk) begin
    if (!rst_n) vld_q <= '0;
    else        vld_q <= {vld_q[LAT-2:0], in_valid};
  end

  always_ff @(posedge clk) begin
    idx_q[0] <= in_idx;
    dat_q[0] <= in_data;
    for (int k = 1; k < LAT; k++) begin
      idx_q[k] <= idx_q[k-1];
      dat_q[k] <= dat_q[k-1];
    end
  end

  assign wb_valid = vld_q[LAT-1];
  assign wb_idx   = idx_q[LAT-1];
  assign wb_data  = dat_q[LAT-1];

  // R5
  wb_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wb_valid && $past(wb_valid)) |-> (wb_idx == IDX_W'($past(wb_idx) + 1'b1)));
endmodule

// File: rtl/vmem_stride_unit.sv
module vmem_stride_unit #(
  parameter int BANKS  = 16,
  parameter int ROWS   = 16,
  parameter int LAT    = 11,
  parameter int MAXLEN = 64,
  parameter int DW     = 64,
  localparam int AW    = $clog2(BANKS) + $clog2(ROWS),
  localparam int LEN_W = $clog2(MAXLEN + 1),
  localparam int IDX_W = $clog2(MAXLEN)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             vlen_we,
  input  logic [LEN_W-1:0] vlen_in,
  input  logic             stride_we,
  input  logic [AW-1:0]    stride_in,
  input  logic             cmd_valid,
  output logic             cmd_ready,
  input  logic             cmd_store,
  input  logic [AW-1:0]    cmd_base,
  output logic [IDX_W-1:0] src_idx,
  input  logic [DW-1:0]    src_data,
  output logic             wb_valid,
  output logic [IDX_W-1:0] wb_idx,
  output logic [DW-1:0]    wb_data,
  output logic             done
);
  logic [LEN_W-1:0] len_q;
  logic [AW-1:0]    stride_q;
  logic [BANKS-1:0] busy;
  logic             req_valid, req_store;
  logic [AW-1:0]    req_addr;
  logic [IDX_W-1:0] req_idx;
  logic [DW-1:0]    rd_data;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      len_q    <= '0;
      stride_q <= AW'(1);
    end else begin
      if (vlen_we)
        len_q <= (vlen_in > LEN_W'(MAXLEN)) ? LEN_W'(MAXLEN) : vlen_in;
      if (stride_we)
        stride_q <= stride_in;
    end
  end

  assign src_idx = req_idx;

  vsu_addr_gen #(.BANKS(BANKS), .AW(AW), .LEN_W(LEN_W), .IDX_W(IDX_W)) u_agen (
    .clk(clk), .rst_n(rst_n),
    .cmd_valid(cmd_valid), .cmd_store(cmd_store), .cmd_base(cmd_base),
    .cfg_len(len_q), .cfg_stride(stride_q), .busy(busy),
    .ret_valid(wb_valid), .ret_idx(wb_idx),
    .cmd_ready(cmd_ready), .req_valid(req_valid), .req_store(req_store),
    .req_addr(req_addr), .req_idx(req_idx), .done(done)
  );

  vsu_bank_array #(.BANKS(BANKS), .ROWS(ROWS), .LAT(LAT), .DW(DW)) u_banks (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_store(req_store), .req_addr(req_addr),
    .req_wdata(src_data), .busy(busy), .rd_data(rd_data)
  );

  vsu_return_pipe #(.LAT(LAT), .IDX_W(IDX_W), .DW(DW)) u_ret (
    .clk(clk), .rst_n(rst_n),
    .in_valid(req_valid && !req_store), .in_idx(req_idx), .in_data(rd_data),
    .wb_valid(wb_valid), .wb_idx(wb_idx), .wb_data(wb_data)
  );
endmodule

// File: tb/vmem_stride_unit_test.sv
module vmem_stride_unit_test;
  localparam int CLK_P = 10;
  localparam int LAT   = 11;
  localparam int WORDS = 256;
  localparam int WD    = 3000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        vlen_we = 1'b0, stride_we = 1'b0;
  logic [6:0]  vlen_in = '0;
  logic [7:0]  stride_in = '0;
  logic        cmd_valid = 1'b0, cmd_store = 1'b0;
  logic [7:0]  cmd_base = '0;
  logic        cmd_ready, wb_valid, done;
  logic [5:0]  src_idx, wb_idx;
  logic [63:0] src_data, wb_data;

  int unsigned cur_salt = 0;
  int          total = 0, bad = 0;
  logic [63:0] shm [WORDS];

  always #(CLK_P/2) clk = ~clk;

  function automatic logic [63:0] pat(int unsigned salt, int unsigned i);
    return {salt ^ 32'h9e37_79b9, i * 32'h0100_0193 + salt};
  endfunction

  assign src_data = pat(cur_salt, 32'(src_idx));

  vmem_stride_unit uut (
    .clk(clk), .rst_n(rst_n), .vlen_we(vlen_we), .vlen_in(vlen_in),
    .stride_we(stride_we), .stride_in(stride_in), .cmd_valid(cmd_valid),
    .cmd_ready(cmd_ready), .cmd_store(cmd_store), .cmd_base(cmd_base),
    .src_idx(src_idx), .src_data(src_data), .wb_valid(wb_valid),
    .wb_idx(wb_idx), .wb_data(wb_data), .done(done)
  );

  task automatic chk(bit ok, string req, logic [63:0] act, logic [63:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic int exp_edges(int v, int base, int stride, bit st);
    int fr[16];
    int t, last, a, b, te;
    foreach (fr[k]) fr[k] = 0;
    t = 1; last = 0;
    for (int i = 0; i < v; i++) begin
      a = (base + i * stride) % WORDS;
      b = a % 16;
      te = (t > fr[b]) ? t : fr[b];
      fr[b] = te + LAT;
      last = te;
      t = te + 1;
    end
    if (v == 0) return 0;
    return st ? last : last + LAT;
  endfunction

  // runs one command; mid=1 rewrites the configuration while it runs (R2)
  task automatic run_cmd(bit st, int base, int vcfg, int stride, int unsigned salt,
                         bit mid, string tag);
    int v, n, wbc, a;
    v = (vcfg > 64) ? 64 : vcfg;
    vlen_we = 1'b1; vlen_in = 7'(vcfg); stride_we = 1'b1; stride_in = 8'(stride);
    @(posedge clk); #1;
    vlen_we = 1'b0; stride_we = 1'b0;
    cur_salt = salt;
    chk(cmd_ready == 1'b1, "R10 ready idle", 64'(cmd_ready), 64'd1);
    cmd_valid = 1'b1; cmd_store = st; cmd_base = 8'(base);
    @(posedge clk); #1;
    cmd_valid = 1'b0;
    n = 0; wbc = 0;
    forever begin
      if (wb_valid) begin
        a = (base + wbc * stride) % WORDS;
        chk(32'(wb_idx) == wbc, "R5 idx", 64'(wb_idx), 64'(wbc));
        chk(wb_data == shm[a], "R5 R3 data", wb_data, shm[a]);
        wbc++;
      end
      if (done) break;
      if (n >= WD) begin
        chk(1'b0, "watchdog", 64'(n), 64'(WD));
        break;
      end
      if (n == 1 && v > 0)
        chk(cmd_ready == 1'b0, "R10 ready busy", 64'(cmd_ready), 64'd0);
      if (mid && n == 2) begin
        vlen_we = 1'b1; vlen_in = 7'd3; stride_we = 1'b1; stride_in = 8'd5;
      end else begin
        vlen_we = 1'b0; stride_we = 1'b0;
      end
      @(posedge clk); #1;
      n++;
    end
    vlen_we = 1'b0; stride_we = 1'b0;
    chk(n == exp_edges(v, base, stride, st), tag, 64'(n), 64'(exp_edges(v, base, stride, st)));
    chk(wbc == (st ? 0 : v), "R5 R9 beat count", 64'(wbc), 64'(st ? 0 : v));
    if (st)
      for (int i = 0; i < v; i++) shm[(base + i * stride) % WORDS] = pat(salt, i);
    @(posedge clk); #1;
    chk(done == 1'b0, "R8 pulse width", 64'(done), 64'd0);
    repeat (15) @(posedge clk);
    #1;
  endtask

  initial begin
    int sel, st, strd;
    void'($urandom(32'd4242));
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    chk(cmd_ready == 1'b1, "R1 ready", 64'(cmd_ready), 64'd1);
    chk(wb_valid == 1'b0, "R1 wb", 64'(wb_valid), 64'd0);
    chk(done == 1'b0, "R1 done", 64'(done), 64'd0);
    // fill memory: unit stride stores (R4 R7)
    for (int q = 0; q < 4; q++) run_cmd(1, q * 64, 64, 1, 32'(100 + q), 0, "R7 store timing");
    run_cmd(0, 0, 50, 1, 0, 0, "R7 unit load timing");
    run_cmd(0, 3, 20, 16, 0, 0, "R6 same-bank load");
    run_cmd(1, 7, 10, 0, 32'd77, 0, "R6 R4 stride0 store");
    run_cmd(0, 0, 30, 8, 0, 0, "R6 two-bank load");
    run_cmd(1, 250, 40, 1, 32'd55, 0, "R3 wrap store");
    run_cmd(0, 0, 100, 1, 0, 0, "R2 clamp load");
    run_cmd(0, 5, 40, 3, 0, 1, "R2 mid-run config");
    run_cmd(1, 0, 0, 1, 32'd999, 0, "R9 zero store");
    run_cmd(0, 0, 0, 1, 0, 0, "R9 zero load");
    run_cmd(0, 0, 64, 4, 0, 0, "R9 R3 memory check");
    run_cmd(1, 9, 64, 128, 32'd31, 0, "R4 overlap store");
    run_cmd(0, 9, 2, 128, 0, 0, "R4 overlap load");
    for (int r = 0; r < 30; r++) begin
      sel = int'($urandom % 7);
      st = int'($urandom % 2);
      case (sel)
        0: strd = 1; 1: strd = 2; 2: strd = 3; 3: strd = 16;
        4: strd = 8; 5: strd = 0; default: strd = int'($urandom % 256);
      endcase
      run_cmd(st[0], int'($urandom % 256), int'($urandom % 70), strd,
              $urandom, 0, "R6 R7 random timing");
    end
    for (int q = 0; q < 4; q++) run_cmd(0, q * 64, 64, 1, 0, 0, "R5 final sweep");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule